// File: doc/BRIEF.md
# Precision Time Counter with Fractional Rate Trimming

This block keeps an 80-bit time of day for stamping Ethernet frames. The time is split into a 48-bit seconds field and a 32-bit sub-second field. The sub-second field counts in binary and rolls over at 2^31. A 32-bit phase accumulator adds a programmable step value on every reference clock cycle. Only a carry out of that accumulator moves the time forward. Each carry adds a programmable increment to the sub-second field. Together, the step value and the increment set a fractional tick rate. Software trims the rate by rewriting the step value while the counter runs.

For a 50 MHz effective tick, the step value is 2^32 divided by the ratio of the reference frequency to 50 MHz, and the increment is 43. For example, a 66 MHz reference needs 0xC1F07C1F. A 65 MHz reference needs 0xC4EC4EC4, and a 67 MHz reference needs 0xBF0B7672.

Software makes large corrections with single-cycle command pulses. A load pulse writes a new time outright. An adjust pulse adds a signed offset to the running time, or subtracts it, in one step. The current time is always visible on the snapshot outputs. Both fields come from one register, so a reader never sees a value torn across a rollover.

Top module: `ptp_systime_gen`

## Requirements
- R1: While rst_n is low, now_sec_o and now_sub_o are zero and the phase accumulator is cleared to zero.
- R2: Each reference cycle, the accumulator becomes (accumulator + addend_i) mod 2^32. The time changes only in a cycle whose sum overflows 32 bits, or in a cycle with a command. With addend_i = 0 and no command, the time never changes.
- R3: On an overflow cycle with no command, now_sub_o gains sub_incr_i (an 8-bit unsigned value). If the result is 2^31 or more, 2^31 is removed from it and now_sec_o gains one, modulo 2^48.
- R4: A load_i pulse sets now_sec_o to adj_sec_i and now_sub_o to adj_sub_i[30:0] on the next cycle. Bit 31 of adj_sub_i is ignored.
- R5: An adjust_i pulse with adj_neg_i = 0 adds the offset (adj_sec_i, adj_sub_i[30:0]) to the time. A sub-second sum of 2^31 or more wraps modulo 2^31 and carries one into the seconds field. The seconds field wraps modulo 2^48.
- R6: An adjust_i pulse with adj_neg_i = 1 subtracts the offset from the time. A sub-second underflow wraps modulo 2^31 and borrows one from the seconds field. The seconds field wraps modulo 2^48.
- R7: load_i takes priority over adjust_i. Either command takes priority over an overflow in the same cycle, so that cycle's increment is dropped. The accumulator still advances in that cycle.
- R8: A new addend_i value is used in the same cycle's accumulation. Changing it does not, by itself, change the time.
- R9: now_sub_o bit 31 is always zero. Both snapshot fields are driven from the same register and change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addend_i | input | 32 | Phase accumulator step value |
| sub_incr_i | input | 8 | Sub-second increment applied per overflow |
| adj_sec_i | input | 48 | Seconds of the load value or offset |
| adj_sub_i | input | 32 | Sub-seconds of the load value or offset (bit 31 ignored) |
| adj_neg_i | input | 1 | Adjust direction: 1 subtracts, 0 adds |
| load_i | input | 1 | Load command pulse |
| adjust_i | input | 1 | Adjust command pulse |
| now_sec_o | output | 48 | Current seconds |
| now_sub_o | output | 32 | Current sub-seconds |

## Verification
A coarse command and an accumulator overflow can fall in the same cycle, and the command must win and the tick must be lost. The bench provokes this directly in two ways. First, it holds addend_i at 0xFFFFFFFF so that nearly every cycle overflows, then pulses load and adjust, including both at once. Second, random stimulus mixes command pulses with random addends. A cycle-level model in the bench predicts each next time. Any cycle where the design applied an increment on top of a command, or dropped a command, shows up as a mismatch on the snapshot outputs.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
    localparam int SEC_W = 48;
    localparam int SUB_W = 32;
    localparam int ACC_W = 32;
    localparam int INC_W = 8;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } ptp_time_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_ADD  = 2'd2,
        CMD_SUB  = 2'd3
    } ptp_cmd_e;
endpackage

// File: rtl/ptp_phase_acc.sv
module ptp_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend_i,
    output logic             carry_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum      = {1'b0, st_q.acc} + {1'b0, addend_i};
        st_d.acc = sum[ACC_W-1:0];
        carry_o  = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    wrap_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> (st_q.acc < $past(st_q.acc)));

    // R2
    grow_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_o |=> (st_q.acc >= $past(st_q.acc)));
endmodule

// File: rtl/ptp_time_adjust.sv
module ptp_time_adjust
    import ptp_time_pkg::*;
(
    input  ptp_time_t        cur_i,
    input  ptp_cmd_e         cmd_i,
    input  logic             tick_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic [SEC_W-1:0] off_sec_i,
    input  logic [SUB_W-1:0] off_sub_i,
    output ptp_time_t        nxt_o
);
    localparam int FR_W = SUB_W - 1;

    logic [FR_W-1:0] off_fr;
    logic [SUB_W:0]  add_s;
    logic [SUB_W:0]  sub_s;
    logic [SUB_W:0]  inc_s;

    always_comb begin
        off_fr = off_sub_i[FR_W-1:0];
        add_s  = {1'b0, cur_i.sub} + {2'b00, off_fr};
        sub_s  = {1'b0, cur_i.sub} - {2'b00, off_fr};
        inc_s  = {1'b0, cur_i.sub} + {{(SUB_W+1-INC_W){1'b0}}, incr_i};
        nxt_o  = cur_i;
        unique case (cmd_i)
            CMD_LOAD: begin
                nxt_o.sec = off_sec_i;
                nxt_o.sub = {1'b0, off_fr};
            end
            CMD_ADD: begin
                nxt_o.sub = {1'b0, add_s[FR_W-1:0]};
                nxt_o.sec = cur_i.sec + off_sec_i + {{(SEC_W-1){1'b0}}, add_s[FR_W]};
            end
            CMD_SUB: begin
                nxt_o.sub = {1'b0, sub_s[FR_W-1:0]};
                nxt_o.sec = cur_i.sec - off_sec_i - {{(SEC_W-1){1'b0}}, sub_s[SUB_W]};
            end
            default: begin
                if (tick_i) begin
                    nxt_o.sub = {1'b0, inc_s[FR_W-1:0]};
                    nxt_o.sec = cur_i.sec + {{(SEC_W-1){1'b0}}, inc_s[FR_W]};
                end
            end
        endcase
    end
endmodule

// File: rtl/ptp_systime_gen.sv
module ptp_systime_gen
    import ptp_time_pkg::*;
(
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend_i,
    input  logic [INC_W-1:0] sub_incr_i,
    input  logic [SEC_W-1:0] adj_sec_i,
    input  logic [SUB_W-1:0] adj_sub_i,
    input  logic             adj_neg_i,
    input  logic             load_i,
    input  logic             adjust_i,
    output logic [SEC_W-1:0] now_sec_o,
    output logic [SUB_W-1:0] now_sub_o
);
    ptp_time_t time_d, time_q;
    ptp_cmd_e  cmd;
    logic      tick;

    ptp_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .addend_i (addend_i),
        .carry_o  (tick)
    );

    always_comb begin
        if (load_i)        cmd = CMD_LOAD;
        else if (adjust_i) cmd = adj_neg_i ? CMD_SUB : CMD_ADD;
        else               cmd = CMD_NONE;
    end

    ptp_time_adjust u_adj (
        .cur_i     (time_q),
        .cmd_i     (cmd),
        .tick_i    (tick),
        .incr_i    (sub_incr_i),
        .off_sec_i (adj_sec_i),
        .off_sub_i (adj_sub_i),
        .nxt_o     (time_d)
    );

    always_ff @(posedge clk_ref) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_d;
    end

    assign now_sec_o = time_q.sec;
    assign now_sub_o = time_q.sub;

    // R9
    sub_range_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        now_sub_o[SUB_W-1] == 1'b0);

    // R2
    idle_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!tick && !load_i && !adjust_i) |=> $stable(time_q));

    // R4
    load_value_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        load_i |=> (now_sec_o == $past(adj_sec_i) &&
                    now_sub_o == {1'b0, $past(adj_sub_i[SUB_W-2:0])}));

    // R7
    cmd_over_tick_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (adjust_i && !load_i && tick && adj_sec_i == '0 &&
         adj_sub_i[SUB_W-2:0] == '0) |=> $stable(time_q));
endmodule

// File: tb/ptp_systime_gen_test.sv
module ptp_systime_gen_test;
    logic        clk_ref = 1'b0;
    logic        rst_n;
    logic [31:0] addend_i;
    logic [7:0]  sub_incr_i;
    logic [47:0] adj_sec_i;
    logic [31:0] adj_sub_i;
    logic        adj_neg_i, load_i, adjust_i;
    logic [47:0] now_sec_o;
    logic [31:0] now_sub_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [47:0] m_sec;
    logic [31:0] m_sub;
    logic [31:0] m_acc;
    logic [31:0] last_add;
    string       tag;

    always #10 clk_ref = ~clk_ref;

    ptp_systime_gen uut (
        .clk_ref(clk_ref), .rst_n(rst_n), .addend_i(addend_i), .sub_incr_i(sub_incr_i),
        .adj_sec_i(adj_sec_i), .adj_sub_i(adj_sub_i), .adj_neg_i(adj_neg_i),
        .load_i(load_i), .adjust_i(adjust_i), .now_sec_o(now_sec_o), .now_sub_o(now_sub_o)
    );

    function automatic string pick_tag(logic carry);
        if (load_i)             return "R4/R7";
        if (adjust_i)           return adj_neg_i ? "R6/R7" : "R5/R7";
        if (addend_i != last_add && !carry) return "R8";
        if (carry)              return "R3";
        return "R2";
    endfunction

    task automatic model_step();
        logic [32:0] s;
        logic        carry;
        s     = {1'b0, m_acc} + {1'b0, addend_i};
        carry = s[32];
        m_acc = s[31:0];
        tag   = pick_tag(carry);
        last_add = addend_i;
        if (load_i) begin
            m_sec = adj_sec_i;
            m_sub = {1'b0, adj_sub_i[30:0]};
        end else if (adjust_i && !adj_neg_i) begin
            s = {1'b0, m_sub} + {2'b00, adj_sub_i[30:0]};
            m_sub = {1'b0, s[30:0]};
            m_sec = m_sec + adj_sec_i + {47'd0, s[31]};
        end else if (adjust_i) begin
            s = {1'b0, m_sub} - {2'b00, adj_sub_i[30:0]};
            m_sub = {1'b0, s[30:0]};
            m_sec = m_sec - adj_sec_i - {47'd0, s[32]};
        end else if (carry) begin
            s = {1'b0, m_sub} + {25'd0, sub_incr_i};
            m_sub = {1'b0, s[30:0]};
            m_sec = m_sec + {47'd0, s[31]};
        end
    endtask

    task automatic compare(string t);
        checks++;
        if (now_sec_o !== m_sec || now_sub_o !== m_sub) begin
            errors++;
            $display("FAIL %s: got sec=%0h sub=%0h expected sec=%0h sub=%0h",
                     t, now_sec_o, now_sub_o, m_sec, m_sub);
        end
        checks++;
        if (now_sub_o[31] !== 1'b0) begin
            errors++;
            $display("FAIL R9: sub bit31=%0b expected 0", now_sub_o[31]);
        end
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk_ref);
        compare(tag);
        load_i = 0;
        adjust_i = 0;
    endtask

    task automatic do_load(logic [47:0] s, logic [31:0] f);
        adj_sec_i = s; adj_sub_i = f; load_i = 1;
        cycle();
    endtask

    task automatic do_adj(logic neg, logic [47:0] s, logic [31:0] f);
        adj_sec_i = s; adj_sub_i = f; adj_neg_i = neg; adjust_i = 1;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk_ref);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1588));
        rst_n = 0; addend_i = 0; sub_incr_i = 8'd43; adj_sec_i = 0; adj_sub_i = 0;
        adj_neg_i = 0; load_i = 0; adjust_i = 0;
        m_sec = 0; m_sub = 0; m_acc = 0; last_add = 0;
        repeat (3) @(negedge clk_ref);
        compare("R1");
        rst_n = 1;

        // R2: zero addend never advances time
        repeat (8) cycle();
        // R3: half-scale addend carries every other cycle
        addend_i = 32'h8000_0000;
        repeat (8) cycle();
        // R4 load with bit31 set (ignored), then R3 rollover near 2^31
        do_load(48'd5, 32'hFFFF_FFF0);
        addend_i = 32'hFFFF_FFFF;
        repeat (6) cycle();
        // R6 borrow on subtract, R5 carry on add
        do_adj(1'b1, 48'd2, 32'h7FFF_FF00);
        do_adj(1'b0, 48'd1, 32'h7FFF_FFFF);
        // R7: commands during near-constant carries, load and adjust together
        do_adj(1'b0, 48'd0, 32'd0);
        load_i = 1; adjust_i = 1; adj_neg_i = 1; adj_sec_i = 48'd9; adj_sub_i = 32'd100;
        cycle();
        // R6: seconds wrap below zero
        do_adj(1'b1, 48'd10, 32'd101);
        // R8: addend changes without carry leave time alone
        do_load(48'd0, 32'd0);
        addend_i = 32'd1;  cycle();
        addend_i = 32'd7;  cycle();
        addend_i = 32'hC1F0_7C1F;
        repeat (10) cycle();

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if ($urandom_range(0, 31) == 0)
                addend_i = (r < 4) ? $urandom() : 32'hC1F0_7C1F + $urandom_range(0, 65535) - 32'd32768;
            sub_incr_i = (r < 8) ? 8'd43 : 8'($urandom_range(0, 255));
            adj_sec_i  = {16'($urandom()), 32'($urandom())};
            if (r == 15) adj_sec_i = {46'd0, 2'($urandom())};
            adj_sub_i  = $urandom();
            adj_neg_i  = 1'($urandom());
            load_i     = ($urandom_range(0, 40) == 0);
            adjust_i   = ($urandom_range(0, 12) == 0);
            cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule